// File: doc/BRIEF.md
# Reset-Latched Debug Mode Controller

This block chooses, each time the chip leaves reset, between booting into a serial debug monitor and booting into normal user code. While the active-low reset is held, it keeps sampling a high-voltage-detect flag, three mode pins and a clock-select pin. When reset is released, it freezes the last sampled values. Later changes on those pins have no effect until the next reset.

From the frozen selection the block produces three things:
- a core clock enable and a bus clock enable, both on the oscillator domain;
- a flag that reports whether the divide-by-two stage is bypassed;
- the high byte of the reset, software-interrupt and break vector fetch addresses.

In monitor mode it also issues a one-cycle request telling the serial port to send a break of ten zero bits. The host times the baud rate from that break. No derived clock nets are created. Downstream logic advances only on the cycles where an enable is high.

All logic runs on the oscillator clock. The reset pin is sampled on that clock, and internally it acts as a synchronous active-high reset. The cycle in which the reset pin is first sampled high is the latch point.

Top module: `boot_mode_ctl`

## Requirements
- R1: Monitor mode (`dbg_mode`=1) is latched only when, on the last clock edge with `rst_n` low, `hv_detect`=1, `sel_a`=1, `sel_b`=0 and `sel_c`=1. Every other combination gives normal mode (`dbg_mode`=0).
- R2: After `rst_n` is sampled high, changes on `hv_detect`, `sel_a`, `sel_b`, `sel_c` and `clk_sel` do not change any output until the next reset.
- R3: In monitor mode with latched `clk_sel`=0, `div_bypass`=1 and `core_en` is high on every cycle.
- R4: In monitor mode with latched `clk_sel`=1, `div_bypass`=0 and `core_en` is high on alternate cycles. Counting from 0 on the first cycle after release, it is high on the odd cycles.
- R5: `bus_en` is high on every second `core_en` cycle. With bypass it is high on run cycles 1, 3, 5 and so on. Without bypass it is high on run cycles 3, 7, 11 and so on.
- R6: `vec_page` is 8'hFE in monitor mode and 8'hFF in normal mode.
- R7: `brk_start` is a single-cycle pulse. It occurs on the first `bus_en` cycle after release, and only in monitor mode.
- R8: In normal mode `clk_sel` is ignored: `div_bypass`=0, `core_en` follows the R4 pattern and `vec_page`=8'hFF.
- R9: While `rst_n` is sampled low, the outputs are held at their defaults: `dbg_mode`=0, `div_bypass`=0, `vec_page`=8'hFF, `core_en`=0, `bus_en`=0 and `brk_start`=0. Within one cycle of reset being asserted, every output returns to these values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset; its release latches the mode |
| hv_detect | input | 1 | High voltage detected on the interrupt pin |
| sel_a | input | 1 | Mode pin A |
| sel_b | input | 1 | Mode pin B |
| sel_c | input | 1 | Mode pin C |
| clk_sel | input | 1 | Clock select; 0 bypasses the divide-by-two in monitor mode |
| dbg_mode | output | 1 | Monitor mode latched |
| div_bypass | output | 1 | Divide-by-two stage bypassed |
| core_en | output | 1 | Core clock enable |
| bus_en | output | 1 | Bus clock enable |
| vec_page | output | 8 | High byte of the vector fetch addresses |
| brk_start | output | 1 | Request for the serial port to send a break |

## Verification
The bench builds the block with its default parameters. With these defaults the phase counter is two bits wide and the vector pages are 8'hFE and 8'hFF.

The bench sweeps all 32 combinations of the five select inputs. For each one it checks the reset defaults, then releases reset and inverts every pin. Over sixteen run cycles it compares each output against patterns worked out arithmetically from the cycle index. It also asserts reset again in the middle of a run to show that every output is cleared.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;
    parameter int PH_W = 2;
    parameter logic [7:0] PAGE_MON = 8'hFE;
    parameter logic [7:0] PAGE_USR = 8'hFF;

    typedef struct packed {
        logic mon;
        logic csel;
    } mode_t;

    function automatic logic is_monitor(input logic hv, input logic a,
                                        input logic b, input logic c);
        return hv & a & ~b & c;
    endfunction
endpackage

// File: rtl/mode_latch.sv
module mode_latch
    import boot_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hv_detect,
    input  logic  sel_a,
    input  logic  sel_b,
    input  logic  sel_c,
    input  logic  clk_sel,
    output mode_t mode,
    output logic  run
);
    logic rst;
    assign rst = ~rst_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode.mon  <= is_monitor(hv_detect, sel_a, sel_b, sel_c);
            mode.csel <= clk_sel;
            run       <= 1'b0;
        end else begin
            run <= 1'b1;
        end
    end

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        run && $past(run) |-> $stable(mode)) else $error("mode changed"); // R2
endmodule

// File: rtl/clk_div.sv
module clk_div
    import boot_mode_pkg::*;
(
    input  logic clk,
    input  logic run,
    input  logic bypass,
    output logic core_en,
    output logic bus_en
);
    logic [PH_W-1:0] ph;

    always_ff @(posedge clk) begin
        if (!run) ph <= '0;
        else      ph <= ph + 1'b1;
    end

    always_comb begin
        core_en = run & (bypass | ph[0]);
        bus_en  = run & (bypass ? ph[0] : (ph == {PH_W{1'b1}}));
    end

    AST_BUS_NEEDS_CORE: assert property (@(posedge clk) disable iff (!run)
        bus_en |-> core_en) else $error("bus without core"); // R5
    AST_BYPASS_FULL: assert property (@(posedge clk) disable iff (!run)
        bypass |-> core_en) else $error("bypass gap"); // R3
    AST_DIV_ALT: assert property (@(posedge clk) disable iff (!run)
        !bypass && core_en |=> !core_en) else $error("divided core twice"); // R4
    AST_RST_QUIET: assert property (@(posedge clk)
        !run |-> !core_en && !bus_en) else $error("enable in reset"); // R9
endmodule

// File: rtl/brk_gen.sv
module brk_gen (
    input  logic clk,
    input  logic run,
    input  logic mon,
    input  logic bus_en,
    output logic brk_start
);
    logic done;

    always_ff @(posedge clk) begin
        if (!run)        done <= 1'b0;
        else if (bus_en) done <= 1'b1;
    end

    assign brk_start = run & mon & bus_en & ~done;

    AST_BRK_MON_ONLY: assert property (@(posedge clk) disable iff (!run)
        brk_start |-> mon && bus_en) else $error("stray break"); // R7
    AST_BRK_SINGLE: assert property (@(posedge clk) disable iff (!run)
        brk_start |=> !brk_start) else $error("break too long"); // R7
endmodule

// File: rtl/boot_mode_ctl.sv
module boot_mode_ctl
    import boot_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hv_detect,
    input  logic       sel_a,
    input  logic       sel_b,
    input  logic       sel_c,
    input  logic       clk_sel,
    output logic       dbg_mode,
    output logic       div_bypass,
    output logic       core_en,
    output logic       bus_en,
    output logic [7:0] vec_page,
    output logic       brk_start
);
    mode_t mode;
    logic  run;

    mode_latch u_latch (
        .clk(clk), .rst_n(rst_n), .hv_detect(hv_detect), .sel_a(sel_a),
        .sel_b(sel_b), .sel_c(sel_c), .clk_sel(clk_sel),
        .mode(mode), .run(run)
    );

    always_comb begin
        dbg_mode   = run & mode.mon;
        div_bypass = run & mode.mon & ~mode.csel;
        vec_page   = dbg_mode ? PAGE_MON : PAGE_USR;
    end

    clk_div u_div (
        .clk(clk), .run(run), .bypass(div_bypass),
        .core_en(core_en), .bus_en(bus_en)
    );

    brk_gen u_brk (
        .clk(clk), .run(run), .mon(dbg_mode), .bus_en(bus_en),
        .brk_start(brk_start)
    );

    AST_USR_NO_BYPASS: assert property (@(posedge clk) disable iff (!run)
        !dbg_mode |-> !div_bypass) else $error("bypass in user mode"); // R8
endmodule

// File: tb/boot_mode_ctl_tb.sv
module boot_mode_ctl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hv_detect = 1'b0, sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0, clk_sel = 1'b0;
    logic dbg_mode, div_bypass, core_en, bus_en, brk_start;
    logic [7:0] vec_page;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    boot_mode_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .hv_detect(hv_detect), .sel_a(sel_a),
        .sel_b(sel_b), .sel_c(sel_c), .clk_sel(clk_sel),
        .dbg_mode(dbg_mode), .div_bypass(div_bypass), .core_en(core_en),
        .bus_en(bus_en), .vec_page(vec_page), .brk_start(brk_start)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_defaults(input string req);
        chk(req, {7'd0, dbg_mode}, 8'd0);
        chk(req, {7'd0, div_bypass}, 8'd0);
        chk(req, vec_page, 8'hFF);
        chk(req, {7'd0, core_en}, 8'd0);
        chk(req, {7'd0, bus_en}, 8'd0);
        chk(req, {7'd0, brk_start}, 8'd0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int v = 0; v < 32; v++) begin
            logic mon, byp;
            @(negedge clk);
            rst_n = 1'b0;
            {hv_detect, sel_a, sel_b, sel_c, clk_sel} = v[4:0];
            repeat (3) @(negedge clk);
            chk_defaults("R9 reset");
            mon = v[4] & v[3] & ~v[2] & v[1];
            byp = mon & ~v[0];
            rst_n = 1'b1;
            @(negedge clk);
            {hv_detect, sel_a, sel_b, sel_c, clk_sel} = ~v[4:0];
            for (int j = 0; j < 16; j++) begin
                logic exp_core, exp_bus, exp_brk;
                exp_core = byp | (j % 2 == 1);
                exp_bus  = byp ? (j % 2 == 1) : (j % 4 == 3);
                exp_brk  = mon & (byp ? (j == 1) : (j == 3));
                chk("R1 R2 mode", {7'd0, dbg_mode}, {7'd0, mon});
                chk("R6 page", vec_page, mon ? 8'hFE : 8'hFF);
                chk(mon ? "R3 R4 bypass" : "R8 bypass", {7'd0, div_bypass}, {7'd0, byp});
                chk(byp ? "R3 core" : (mon ? "R4 core" : "R8 core"),
                    {7'd0, core_en}, {7'd0, exp_core});
                chk("R5 bus", {7'd0, bus_en}, {7'd0, exp_bus});
                chk("R7 break", {7'd0, brk_start}, {7'd0, exp_brk});
                if (j == 8) {hv_detect, sel_a, sel_b, sel_c, clk_sel} = 5'b11010;
                @(negedge clk);
            end
            rst_n = 1'b0;
            @(negedge clk);
            chk_defaults("R9 reassert");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule